// File: doc/BRIEF.md
# Host Debug Port Capture FIFO

This block sits behind a host I/O decoder and records every byte the host writes to a debug port, such as power-on progress codes. Each accepted write becomes one FIFO entry. The entry holds the data byte, the byte lane it arrived on, and a flag that marks it as part of a wider multi-byte host write. No time information is kept. A local processor drains the queue through a small register interface. Each read of the data register pops one entry and returns that entry together with the live FIFO status bits. A level interrupt tells the processor when the queue has filled to a chosen depth.

A three-state controller governs capture:

- `ST_OFF`: nothing is captured. This is the state after reset and after a soft reset.
- `ST_ON`: qualified host writes are queued.
- `ST_FLUSH`: a one-cycle state entered from any state when software sets the soft-reset bit. It empties the queue and returns the registers to their reset values.

The transitions are:

- `OFF->ON`: activate is written with 1.
- `ON->OFF`: activate is written with 0.
- `ANY->FLUSH`: the soft-reset bit is written.
- `FLUSH->OFF`: taken unconditionally.

Software normally issues a soft reset, then sets the threshold, the interrupt enable and activate, in that order.

Top module: `dbgcap_top`

## Requirements
- R1: After reset:
  - the status register (address 3) reads 0;
  - the activate register (address 2) reads 0;
  - `irq` is low.
- R2: A host write is queued only when `host_wr` and `host_hit` are both high in state `ST_ON`. A write is ignored when `host_hit` is low. A write is also ignored in `ST_OFF`.
- R3: A data read (address 4) of a non-empty FIFO returns:
  - the captured byte in bits [7:0];
  - the byte lane in bits [9:8];
  - the multi-byte flag in bit 10;
  - zero in bits [12:11].
- R4: Bits [15:13] of a data read are live status: bit 15 not-empty, bit 14 full and bit 13 overrun. They reflect the state before the pop.
- R5: The FIFO holds DEPTH (default 32) entries and returns them in arrival order.
- R6: A data read with `reg_rd` high pops one entry. A read of an empty FIFO returns 0 in bits [12:0] and changes neither the pointers nor the occupancy.
- R7: A qualified host write that arrives while the FIFO is full is dropped, and the sticky overrun bit (status bit 2) is set. Writing 1 to status bit 2 clears it.
- R8: Configuration bits [1:0] select the threshold: 0→1, 1→DEPTH/8, 2→DEPTH/2, 3→DEPTH-4 (28 by default). Interrupt-enable register (address 1) bit 0 gates `irq`. `irq` is high exactly while the enable is set and the occupancy is at or above the threshold.
- R9: Writing configuration (address 0) with bit 7 set enters `ST_FLUSH` at the next edge. One cycle later the block is in `ST_OFF` with the following cleared: the FIFO, overrun, the threshold code, the interrupt enable and activate.
- R10: The status register (address 3) reads bit 0 not-empty, bit 1 full, bit 2 overrun and bits [13:8] occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host I/O write strobe, one cycle per byte |
| host_hit | input | 1 | Address decoder matched the debug port |
| host_lane | input | 2 | Byte lane of the written byte |
| host_multi | input | 1 | Byte belongs to a multi-byte host write |
| host_data | input | 8 | Written byte |
| reg_wr | input | 1 | Local register write strobe |
| reg_rd | input | 1 | Local register read strobe (pops on the data address) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on `reg_addr` |
| irq | output | 1 | Threshold interrupt, level high |

## Verification
The hardest condition to reach from the ports is a write dropped on a full queue. That condition must also be told apart from a normal push. The stimulus fills the FIFO with 32 distinct entries, each with its own byte, lane and multi-byte pattern. It then sends one more write with a marker value. The bench checks that the occupancy stays at 32 and that overrun sets. It then drains all 32 entries and checks that the marker never appears and that the full and overrun bits in each read follow the occupancy. The threshold edge at 28 entries is approached one write at a time, and `irq` is checked just before the crossing, just after it, and again after a single pop.

// File: rtl/dbgcap_pkg.sv
package dbgcap_pkg;

    typedef struct packed {
        logic       multi;
        logic [1:0] lane;
        logic [7:0] data;
    } cap_entry_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ON    = 2'd1,
        ST_FLUSH = 2'd2
    } cap_state_t;

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_IEN  = 3'd1;
    localparam logic [2:0] A_ACT  = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_DATA = 3'd4;

endpackage

// File: rtl/dbgcap_fifo.sv
module dbgcap_fifo
    import dbgcap_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic                         pop,
    input  cap_entry_t                   wr_entry,
    output cap_entry_t                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    cap_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_q] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R2
    no_phantom_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !clr) |=> (cnt_q <= $past(cnt_q)));

    // R6
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> ($stable(rd_q) && $stable(cnt_q)));

endmodule

// File: rtl/dbgcap_ctrl.sv
module dbgcap_ctrl
    import dbgcap_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_wr,
    input  logic                        host_hit,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [2:0]                  reg_addr,
    input  logic [7:0]                  reg_wdata,
    input  cap_entry_t                  head,
    input  logic [$clog2(DEPTH+1)-1:0]  count,
    input  logic                        full,
    input  logic                        empty,
    output logic                        push,
    output logic                        pop,
    output logic                        clr,
    output logic [15:0]                 reg_rdata,
    output logic                        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] TH0 = CNT_W'(1);
    localparam logic [CNT_W-1:0] TH1 = CNT_W'(DEPTH / 8);
    localparam logic [CNT_W-1:0] TH2 = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] TH3 = CNT_W'(DEPTH - 4);

    cap_state_t       state_q, state_d;
    logic [1:0]       thr_q;
    logic             ien_q, ovr_q;
    logic             cap_req, srst_wr, act_wr;
    logic [CNT_W-1:0] thr_val;
    logic             unused_wd;

    assign unused_wd = ^reg_wdata[6:3];
    assign cap_req   = host_wr && host_hit && (state_q == ST_ON);
    assign srst_wr   = reg_wr && (reg_addr == A_CFG) && reg_wdata[7];
    assign act_wr    = reg_wr && (reg_addr == A_ACT) && (state_q != ST_FLUSH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (srst_wr) begin
            state_d = ST_FLUSH;
        end else begin
            unique case (state_q)
                ST_OFF:   if (act_wr && reg_wdata[0])  state_d = ST_ON;
                ST_ON:    if (act_wr && !reg_wdata[0]) state_d = ST_OFF;
                ST_FLUSH: state_d = ST_OFF;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // outputs to the queue
    always_comb begin
        push = 1'b0;
        pop  = 1'b0;
        clr  = 1'b0;
        unique case (state_q)
            ST_FLUSH: clr = 1'b1;
            ST_ON: begin
                push = cap_req;
                pop  = reg_rd && (reg_addr == A_DATA);
            end
            default: pop = reg_rd && (reg_addr == A_DATA);
        endcase
    end

    // configuration, enable and sticky overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
            ien_q <= 1'b0;
            ovr_q <= 1'b0;
        end else if (state_q == ST_FLUSH) begin
            thr_q <= '0;
            ien_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CFG && !reg_wdata[7]) thr_q <= reg_wdata[1:0];
            if (reg_wr && reg_addr == A_IEN) ien_q <= reg_wdata[0];
            if (cap_req && full) ovr_q <= 1'b1;
            else if (reg_wr && reg_addr == A_STAT && reg_wdata[2]) ovr_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (thr_q)
            2'd0:    thr_val = TH0;
            2'd1:    thr_val = TH1;
            2'd2:    thr_val = TH2;
            default: thr_val = TH3;
        endcase
    end

    assign irq = ien_q && (count >= thr_val);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CFG:  reg_rdata[1:0] = thr_q;
            A_IEN:  reg_rdata[0]   = ien_q;
            A_ACT:  reg_rdata[0]   = (state_q == ST_ON);
            A_STAT: reg_rdata = {2'b00, 6'(count), 5'b0, ovr_q, full, !empty};
            A_DATA: begin
                reg_rdata[15:13] = {!empty, full, ovr_q};
                if (!empty) reg_rdata[10:0] = head;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_hit && state_q == ST_ON && full && state_d != ST_FLUSH) |=> ovr_q);

    // R9
    flush_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH && !srst_wr) |=> (state_q == ST_OFF && !ovr_q && !ien_q && thr_q == 2'd0));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q && !empty));

endmodule

// File: rtl/dbgcap_top.sv
module dbgcap_top
    import dbgcap_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_hit,
    input  logic [1:0]  host_lane,
    input  logic        host_multi,
    input  logic [7:0]  host_data,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    cap_entry_t       wr_entry, head;
    logic [CNT_W-1:0] count;
    logic             full, empty, push, pop, clr;

    assign wr_entry = '{multi: host_multi, lane: host_lane, data: host_data};

    dbgcap_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .pop(pop),
        .wr_entry(wr_entry), .head(head), .count(count),
        .full(full), .empty(empty)
    );

    dbgcap_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_hit(host_hit),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .head(head), .count(count), .full(full),
        .empty(empty), .push(push), .pop(pop), .clr(clr),
        .reg_rdata(reg_rdata), .irq(irq)
    );

endmodule

// File: tb/dbgcap_top_tb_top.sv
module dbgcap_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_hit = 1'b0, host_multi = 1'b0;
    logic [1:0]  host_lane = '0;
    logic [7:0]  host_data = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    dbgcap_top dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_hit(host_hit),
        .host_lane(host_lane), .host_multi(host_multi), .host_data(host_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [7:0] dval(int i);
        return 8'(i * 7 + 3);
    endfunction
    function automatic logic [10:0] eval(int i);
        return {i[0], 2'(i % 4), dval(i)};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [7:0] d, logic [1:0] ln, logic m, logic hit);
        @(negedge clk);
        host_wr = 1'b1; host_hit = hit; host_data = d; host_lane = ln; host_multi = m;
        @(posedge clk); #1;
        host_wr = 1'b0; host_hit = 1'b0;
    endtask

    task automatic rwrite(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; #1;
        v = reg_rdata;
    endtask

    task automatic popread(output logic [15:0] v);
        @(negedge clk);
        reg_addr = 3'd4; reg_rd = 1'b1; #1;
        v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic softreset();
        rwrite(3'd0, 8'h80);
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(3'd3, v); chk("R1 status", v, 16'h0);
        peek(3'd2, v); chk("R1 activate", v, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_ignore();
        logic [15:0] v;
        hwrite(8'h11, 2'd0, 1'b0, 1'b1);
        peek(3'd3, v); chk("R2 write while off ignored", v, 16'h0);
        rwrite(3'd2, 8'h01);
        peek(3'd2, v); chk("R2 activate reads 1", v, 16'h1);
        hwrite(8'h22, 2'd1, 1'b0, 1'b0);
        peek(3'd3, v); chk("R2 no hit ignored", v, 16'h0);
    endtask

    task automatic t_format();
        logic [15:0] v;
        hwrite(8'hA5, 2'd3, 1'b1, 1'b1);
        hwrite(8'h5A, 2'd2, 1'b0, 1'b1);
        peek(3'd3, v); chk("R10 status two entries", v, 16'h0201);
        popread(v); chk("R3 R4 first entry", v, 16'h8000 | 16'h07A5);
        popread(v); chk("R3 second entry", v, 16'h8000 | 16'h025A);
        peek(3'd3, v); chk("R6 empty after pops", v, 16'h0);
        popread(v); chk("R6 empty read", v, 16'h0);
        peek(3'd3, v); chk("R6 empty read no change", v, 16'h0);
        hwrite(8'h33, 2'd1, 1'b0, 1'b1);
        popread(v); chk("R6 pointers intact", v, 16'h8133);
    endtask

    task automatic t_fill();
        logic [15:0] v;
        for (int i = 0; i < 32; i++) hwrite(dval(i), 2'(i % 4), i[0], 1'b1);
        peek(3'd3, v); chk("R5 full status", v, 16'h2003);
        hwrite(8'hEE, 2'd0, 1'b0, 1'b1);
        peek(3'd3, v); chk("R7 drop sets overrun", v, 16'h2007);
        for (int i = 0; i < 32; i++) begin
            popread(v);
            chk("R5 R7 order", v, {1'b1, (i == 0), 1'b1, 2'b00, eval(i)});
        end
        peek(3'd3, v); chk("R7 overrun sticky", v, 16'h0004);
        rwrite(3'd3, 8'h04);
        peek(3'd3, v); chk("R7 overrun cleared", v, 16'h0);
    endtask

    task automatic t_thresh();
        logic [15:0] v;
        rwrite(3'd0, 8'h03);
        rwrite(3'd1, 8'h01);
        for (int i = 0; i < 27; i++) hwrite(dval(i), 2'd0, 1'b0, 1'b1);
        @(negedge clk); chk("R8 irq below 28", {15'b0, irq}, 16'h0);
        hwrite(8'h44, 2'd0, 1'b0, 1'b1);
        @(negedge clk); chk("R8 irq at 28", {15'b0, irq}, 16'h1);
        rwrite(3'd1, 8'h00);
        @(negedge clk); chk("R8 irq masked", {15'b0, irq}, 16'h0);
        rwrite(3'd1, 8'h01);
        popread(v);
        @(negedge clk); chk("R8 irq after pop", {15'b0, irq}, 16'h0);
        rwrite(3'd0, 8'h01);
        @(negedge clk); chk("R8 code1 threshold 4", {15'b0, irq}, 16'h1);
    endtask

    task automatic t_softreset();
        logic [15:0] v;
        softreset();
        peek(3'd3, v); chk("R9 fifo cleared", v, 16'h0);
        peek(3'd2, v); chk("R9 activate cleared", v, 16'h0);
        peek(3'd1, v); chk("R9 enable cleared", v, 16'h0);
        peek(3'd0, v); chk("R9 threshold cleared", v, 16'h0);
        hwrite(8'h55, 2'd0, 1'b0, 1'b1);
        peek(3'd3, v); chk("R9 off after flush", v, 16'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_ignore();
        t_format();
        t_fill();
        t_thresh();
        t_softreset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule